// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block governs the low-power states of a small 8-bit microcontroller core. The CPU writes a two-bit power control register. Bit 0 requests idle and bit 1 requests power-down. From the stored bits, a mode state machine derives two clock enables: one for the CPU and one for the peripherals (timers, serial port and interrupt logic). It also drives the external address-latch strobe and the program-store strobe to a fixed level in each low-power mode. In run mode it passes the core's own strobes straight through.

The block leaves idle when any enabled interrupt request is asserted. It leaves power-down only when an enabled external interrupt configured as level-sensitive is asserted. Edge-configured external lines and internal sources do not wake it from power-down. A hardware reset returns the block to its power-on state from any mode.

On a wake the block does three things:
- It clears both mode bits, which stands for the start of interrupt service.
- It pulses a one-cycle wake request to the interrupt controller, so the pending interrupt gets vectored.
- It releases the CPU clock only on the first tick of a machine cycle. This keeps partial cycles away from the CPU.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the register reads 0, both clock enables are 1, the wake request is 0, and the strobe outputs follow the strobe inputs.
- R2: A write with bit 0 set and bit 1 clear in run mode makes the register read back 2'b01 at the next cycle. Two cycles after the write, the CPU clock enable is 0 and the peripheral enable stays 1.
- R3: A write with bit 1 set in run mode enters power-down, in which both clock enables are 0. If bits 0 and 1 are written together, power-down takes precedence and the register reads 2'b11.
- R4: In idle, any request line whose enable is 1 starts a wake at the next clock edge. A request whose enable is 0 leaves the block in idle.
- R5: In power-down, only request lines with index below N_EXT (the external lines) that are enabled and whose level-mode input is 1 start a wake. Edge-mode external lines and internal lines leave the block in power-down.
- R6: A wake clears the register to 0 and raises the wake request for exactly one cycle, in the cycle that follows the waking edge.
- R7: After a wake, the CPU clock enable returns to 1 only when the machine-cycle phase counter is 0. The phase counter runs free from 0 to PH_N-1 and restarts at 0 on reset. The return happens within PH_N cycles of the wake.
- R8: Both strobes are forced to 1 in idle and to 0 in power-down, including the wake wait that follows each mode. In run mode they follow their inputs.
- R9: A reset in either low-power mode returns the block to the state of R1 at the next cycle.
- R10: Register writes are ignored whenever the block is not in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_wr | input | 1 | Power control register write strobe |
| reg_wdata | input | 2 | Write data: bit 0 idle request, bit 1 power-down request |
| reg_rdata | output | 2 | Current register bits, same layout |
| irq_req | input | N_IRQ | Interrupt request lines; the low N_EXT are external |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| ext_level | input | N_EXT | 1 = the external line is level-sensitive |
| ale_in | input | 1 | Address-latch strobe from the core |
| psen_in | input | 1 | Program-store strobe from the core |
| ale_out | output | 1 | Address-latch strobe to the pin |
| psen_out | output | 1 | Program-store strobe to the pin |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wake_pulse | output | 1 | One-cycle wake request to the interrupt controller |

## Verification
The assertions assume that reset is held for at least one clock edge before any other stimulus. They also assume that interrupt requests and enables are synchronous to the block clock and change only between edges. The stimulus drives every input on the falling edge and asserts reset from time zero. It sweeps every request line, enable value and level-mode setting through both low-power modes. Each scenario that does not wake is ended by a reset, so that every scenario starts from the R1 state.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    // Control register bit positions
    localparam int IDL_BIT = 0;
    localparam int PD_BIT  = 1;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_PDOWN  = 3'd2,
        ST_WAKE_I = 3'd3,
        ST_WAKE_P = 3'd4
    } pmc_state_e;

    typedef struct packed {
        logic pd;
        logic idl;
    } pcr_t;

    typedef struct packed {
        logic cpu;
        logic per;
    } clk_en_t;

    typedef enum logic [1:0] {
        STB_PASS = 2'd0,
        STB_HIGH = 2'd1,
        STB_LOW  = 2'd2
    } stb_mode_e;

    // Power-down wins over idle
    function automatic pmc_state_e mode_from_bits(pcr_t b);
        if (b.pd)       return ST_PDOWN;
        else if (b.idl) return ST_IDLE;
        else            return ST_RUN;
    endfunction

    function automatic stb_mode_e strobe_mode(pmc_state_e s);
        case (s)
            ST_IDLE, ST_WAKE_I:  return STB_HIGH;
            ST_PDOWN, ST_WAKE_P: return STB_LOW;
            default:             return STB_PASS;
        endcase
    endfunction

    function automatic clk_en_t clk_enables(pmc_state_e s);
        clk_en_t c;
        c.cpu = (s == ST_RUN);
        c.per = (s != ST_PDOWN);
        return c;
    endfunction

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ok,
    input  logic [1:0] wdata,
    input  logic       clr,
    output pcr_t       bits,
    output logic [1:0] rdata
);
    pcr_t bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (clr) begin
            bits_q <= '0;
        end else if (wr_ok) begin
            bits_q.idl <= wdata[IDL_BIT];
            bits_q.pd  <= wdata[PD_BIT];
        end
    end

    always_comb begin
        rdata         = '0;
        rdata[IDL_BIT] = bits_q.idl;
        rdata[PD_BIT]  = bits_q.pd;
    end

    assign bits = bits_q;

    // R6
    bits_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bits_q == '0));

    // R10
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_ok && !clr) |=> $stable(bits_q));

endmodule

// File: rtl/pmc_wake.sv
module pmc_wake #(
    parameter int N_IRQ = 6,
    parameter int N_EXT = 2
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_EXT-1:0] ext_level,
    output logic             any_wake,
    output logic             lvl_wake
);
    logic [N_IRQ-1:0] active;
    logic [N_IRQ-1:0] lvl_active;

    assign active = irq_req & irq_en;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        if (i < N_EXT) begin : g_ext
            assign lvl_active[i] = active[i] & ext_level[i];
        end else begin : g_int
            assign lvl_active[i] = 1'b0;
        end
    end

    assign any_wake = |active;
    assign lvl_wake = |lvl_active;

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int PH_N = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  pcr_t       bits,
    input  logic       any_wake,
    input  logic       lvl_wake,
    output pmc_state_e state,
    output logic       clr,
    output logic       wake_o,
    output clk_en_t    clk_en
);
    localparam int PW = (PH_N > 1) ? $clog2(PH_N) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(PH_N - 1);

    pmc_state_e state_q, state_d;
    logic [PW-1:0] phase_q;
    logic wake_q;

    always_ff @(posedge clk) begin
        if (rst)                   phase_q <= '0;
        else if (phase_q == PH_LAST) phase_q <= '0;
        else                       phase_q <= phase_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        clr     = 1'b0;
        case (state_q)
            ST_RUN:   state_d = mode_from_bits(bits);
            ST_IDLE: if (any_wake) begin
                state_d = ST_WAKE_I;
                clr     = 1'b1;
            end
            ST_PDOWN: if (lvl_wake) begin
                state_d = ST_WAKE_P;
                clr     = 1'b1;
            end
            ST_WAKE_I, ST_WAKE_P: if (phase_q == PH_LAST) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= clr;
        end
    end

    assign state  = state_q;
    assign wake_o = wake_q;
    assign clk_en = clk_enables(state_q);

    // R7
    cpu_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en.cpu) |-> (phase_q == '0));

    // R6
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_q |=> !wake_q);

    // R4
    idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && any_wake) |=> (state_q == ST_WAKE_I));

    // R5
    pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PDOWN && !lvl_wake) |=> (state_q == ST_PDOWN));

endmodule

// File: rtl/pmc_strobe.sv
module pmc_strobe
    import pmc_pkg::*;
#(
    parameter int N_STB = 2
) (
    input  pmc_state_e       state,
    input  logic [N_STB-1:0] stb_in,
    output logic [N_STB-1:0] stb_out
);
    stb_mode_e mode;
    assign mode = strobe_mode(state);

    for (genvar i = 0; i < N_STB; i++) begin : g_stb
        always_comb begin
            case (mode)
                STB_HIGH: stb_out[i] = 1'b1;
                STB_LOW:  stb_out[i] = 1'b0;
                default:  stb_out[i] = stb_in[i];
            endcase
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int N_IRQ = 6,
    parameter int N_EXT = 2,
    parameter int PH_N  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_wdata,
    output logic [1:0]       reg_rdata,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_EXT-1:0] ext_level,
    input  logic             ale_in,
    input  logic             psen_in,
    output logic             ale_out,
    output logic             psen_out,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             wake_pulse
);
    localparam int N_STB = 2;

    pcr_t       bits;
    pmc_state_e state;
    logic       clr, any_wake, lvl_wake, wr_ok;
    clk_en_t    clk_en;
    logic [N_STB-1:0] stb_in, stb_out;

    assign wr_ok = reg_wr && (state == ST_RUN);

    pmc_ctrl_reg u_reg (
        .clk(clk), .rst(rst), .wr_ok(wr_ok), .wdata(reg_wdata),
        .clr(clr), .bits(bits), .rdata(reg_rdata)
    );

    pmc_wake #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_wake (
        .irq_req(irq_req), .irq_en(irq_en), .ext_level(ext_level),
        .any_wake(any_wake), .lvl_wake(lvl_wake)
    );

    pmc_fsm #(.PH_N(PH_N)) u_fsm (
        .clk(clk), .rst(rst), .bits(bits), .any_wake(any_wake),
        .lvl_wake(lvl_wake), .state(state), .clr(clr),
        .wake_o(wake_pulse), .clk_en(clk_en)
    );

    assign stb_in = {psen_in, ale_in};

    pmc_strobe #(.N_STB(N_STB)) u_stb (
        .state(state), .stb_in(stb_in), .stb_out(stb_out)
    );

    assign ale_out    = stb_out[0];
    assign psen_out   = stb_out[1];
    assign cpu_clk_en = clk_en.cpu;
    assign per_clk_en = clk_en.per;

    // R8
    idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (ale_out && psen_out));

    // R8
    pd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PDOWN) |-> (!ale_out && !psen_out));

    // R3
    pd_clocks_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PDOWN) |-> (!cpu_clk_en && !per_clk_en));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (reg_rdata == 2'b00 && cpu_clk_en && per_clk_en && !wake_pulse));

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    localparam int N_IRQ = 6;
    localparam int N_EXT = 2;
    localparam int PH_N  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [1:0] reg_wdata = '0;
    logic [1:0] reg_rdata;
    logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
    logic [N_EXT-1:0] ext_level = '0;
    logic ale_in = 1'b0, psen_in = 1'b0;
    logic ale_out, psen_out, cpu_clk_en, per_clk_en, wake_pulse;

    int n_chk = 0, n_fail = 0, bph = 0, cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(N_IRQ), .N_EXT(N_EXT), .PH_N(PH_N)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_en(irq_en),
        .ext_level(ext_level), .ale_in(ale_in), .psen_in(psen_in),
        .ale_out(ale_out), .psen_out(psen_out), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .wake_pulse(wake_pulse)
    );

    // Machine-cycle phase model from R7
    always @(posedge clk) begin
        if (rst) bph <= 0;
        else     bph <= (bph == PH_N - 1) ? 0 : bph + 1;
        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string tag);
        chk(reg_rdata == 2'b00, {tag, " rdata"}, reg_rdata, 0);
        chk(cpu_clk_en && per_clk_en, {tag, " clk_en"}, {cpu_clk_en, per_clk_en}, 3);
        chk(!wake_pulse, {tag, " wake"}, wake_pulse, 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic write_reg(input logic [1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // One sweep point: pd selects the mode, line/en/lvl select the request
    task automatic scenario(input bit pd, input int line, input bit en, input bit lvl);
        bit exp_wake, seen;
        logic [1:0] exp_bits;
        exp_bits = pd ? 2'b10 : 2'b01;
        exp_wake = pd ? (en && line < N_EXT && lvl) : en;
        irq_en    = en ? (N_IRQ'(1) << line) : '0;
        ext_level = lvl ? '1 : '0;
        ale_in = pd; psen_in = pd;  // opposite of the forced level
        write_reg(exp_bits);
        chk(reg_rdata == exp_bits, pd ? "R3 rdata" : "R2 rdata", reg_rdata, exp_bits);
        @(negedge clk);
        chk(!cpu_clk_en, pd ? "R3 cpu_en" : "R2 cpu_en", cpu_clk_en, 0);
        chk(per_clk_en == !pd, pd ? "R3 per_en" : "R2 per_en", per_clk_en, !pd);
        chk(ale_out == !pd && psen_out == !pd, "R8 strobes", {psen_out, ale_out}, pd ? 0 : 3);
        // R10: write ignored while in low-power mode
        write_reg(2'b00);
        chk(reg_rdata == exp_bits, "R10 write ignored", reg_rdata, exp_bits);
        irq_req = N_IRQ'(1) << line;
        @(negedge clk);
        if (exp_wake) begin
            chk(wake_pulse, "R6 wake pulse", wake_pulse, 1);
            chk(reg_rdata == 2'b00, "R6 bits cleared", reg_rdata, 0);
            chk(ale_out == !pd && psen_out == !pd, "R8 wait strobes", {psen_out, ale_out}, pd ? 0 : 3);
            irq_req = '0;
            seen = 1'b0;
            for (int k = 0; k < PH_N + 1 && !seen; k++) begin
                @(negedge clk);
                if (k == 0) chk(!wake_pulse, "R6 pulse width", wake_pulse, 0);
                if (cpu_clk_en) seen = 1'b1;
            end
            chk(seen, "R7 cpu_en returns", seen, 1);
            chk(bph == 0, "R7 phase boundary", bph, 0);
            chk(ale_out == ale_in && psen_out == psen_in, "R8 pass after wake",
                {psen_out, ale_out}, {psen_in, ale_in});
        end else begin
            for (int k = 0; k < 3; k++) begin
                chk(!wake_pulse && !cpu_clk_en, pd ? "R5 no wake" : "R4 no wake",
                    {wake_pulse, cpu_clk_en}, 0);
                @(negedge clk);
            end
            chk(reg_rdata == exp_bits, pd ? "R5 bits held" : "R4 bits held", reg_rdata, exp_bits);
            irq_req = '0;
            do_reset();
            chk_reset_state("R9 reset from low power");
        end
        irq_en = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_reset_state("R1 reset");
        // R1, R8: pass-through in run mode
        for (int v = 0; v < 4; v++) begin
            ale_in = v[0]; psen_in = v[1];
            #1;
            chk(ale_out == v[0] && psen_out == v[1], "R1 strobe pass", {psen_out, ale_out}, v);
            @(negedge clk);
        end
        // R3: both bits together -> power-down
        write_reg(2'b11);
        chk(reg_rdata == 2'b11, "R3 both bits rdata", reg_rdata, 3);
        @(negedge clk);
        chk(!cpu_clk_en && !per_clk_en, "R3 both bits pd", {cpu_clk_en, per_clk_en}, 0);
        do_reset();
        chk_reset_state("R9 after both bits");
        for (int pd = 0; pd < 2; pd++)
            for (int line = 0; line < N_IRQ; line++)
                for (int en = 0; en < 2; en++)
                    for (int lvl = 0; lvl < 2; lvl++)
                        scenario(pd[0], line, en[0], lvl[0]);
        done = 1'b1;
    end

    initial begin
        wait (done || cyc > 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule